// File: doc/BRIEF.md
# Halving XOR Phase-Frequency Detector

This block compares a reference pulse train with an oscillator pulse train, both sampled on a fast system clock, and produces a pulse-width-modulated error signal for a phase-locked loop. Each input is halved by a toggle stage that advances only on rising edges. The two halved square waves are combined by an XOR, so the pulse width of the output follows the offset between the input edges and no dead zone occurs near lock. At a half-period offset the output duty cycle is 50%.

Away from lock, two discrimination flags take over. If one input gives two rising edges with no rising edge on the other input in between, the matching flag sets and overrides the XOR. A slow oscillator forces the output high. A fast oscillator forces it low. A flag clears on the next rising edge of the lagging input. The block drives a true output and a complementary output, both registered.

Top module: `pfd_xor_disc`

## Requirements
- R1: While reset is asserted, and afterwards until input edges arrive, out_o is 0 and out_no is 1.
- R2: Each input is halved on its rising edges only, so the high time of either input has no effect on the output.
- R3: With equal input periods T, where the oscillator rising edge follows the reference rising edge by d cycles (0 < d < T), out_o is high for d of every T cycles. When the oscillator leads the reference by d cycles, the result is also d of every T cycles.
- R4: At an offset of half a period (d = T/2), the measured duty cycle is exactly 50%.
- R5: The duty cycle rises strictly as d grows, from 0 up to T-1.
- R6: Two reference rising edges with no oscillator rising edge in between set the frequency-low flag. While the flag is set, out_o is forced to 1 on the following cycle. With the reference at four times the oscillator frequency, the mean is above 55%.
- R7: Two oscillator rising edges with no reference rising edge in between set the frequency-high flag. While the flag is set, out_o is forced to 0 on the following cycle. With the oscillator at four times the reference frequency, the mean is below 45%.
- R8: The frequency-low flag clears on the next oscillator rising edge, and the frequency-high flag clears on the next reference rising edge. The two flags are never set together, and once the frequencies match, phase control resumes.
- R9: Rising edges that reach both inputs in the same cycle count as one edge each. They never set a flag, so inputs aligned in phase give a constant 0.
- R10: out_no is the complement of out_o on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_i | input | 1 | Reference pulse train, asynchronous |
| osc_i | input | 1 | Oscillator pulse train, asynchronous |
| out_o | output | 1 | Error output, noninverted |
| out_no | output | 1 | Error output, inverted |

## Verification
The assertions check the following on every clock cycle:
- each edge pulse lasts one cycle;
- a halving stage flips on every edge;
- a set flag forces the output level on the next cycle;
- flags clear on the opposing edge, and simultaneous edges set no flag;
- the flags are mutually exclusive;
- the two outputs stay complementary.

Some properties show up only over many input periods, so the bench's scenarios cover them. These are the exact duty cycle at each offset, its monotonic rise, its insensitivity to input pulse width, the mean shift under a frequency mismatch, and the return to phase control once the frequencies match again.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  localparam int unsigned PFD_SYNC_DEPTH = 2;

  typedef struct packed {
    logic lo;  // oscillator too slow
    logic hi;  // oscillator too fast
  } fd_flags_t;
endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
  parameter int unsigned STAGES = pfd_pkg::PFD_SYNC_DEPTH
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], in_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

  AST_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R2
endmodule

// File: rtl/pfd_half.sv
module pfd_half (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rise_i,
  output logic half_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     half_o <= 1'b0;
    else if (rise_i) half_o <= ~half_o;
  end

  AST_HALF_FLIPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_i |=> (half_o != $past(half_o))); // R2
  AST_HALF_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rise_i |=> $stable(half_o)); // R2
endmodule

// File: rtl/pfd_freq_flags.sv
module pfd_freq_flags
  import pfd_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      ref_rise_i,
  input  logic      osc_rise_i,
  output fd_flags_t flags_o
);
  // pend_*: that input has edged since the other one last did
  logic pend_ref_q, pend_osc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_ref_q <= 1'b0;
      pend_osc_q <= 1'b0;
      flags_o    <= '0;
    end else begin
      unique case ({ref_rise_i, osc_rise_i})
        2'b10: begin
          flags_o.lo <= flags_o.lo | pend_ref_q;
          flags_o.hi <= 1'b0;
          pend_ref_q <= 1'b1;
          pend_osc_q <= 1'b0;
        end
        2'b01: begin
          flags_o.hi <= flags_o.hi | pend_osc_q;
          flags_o.lo <= 1'b0;
          pend_osc_q <= 1'b1;
          pend_ref_q <= 1'b0;
        end
        2'b11: begin
          flags_o    <= '0;
          pend_ref_q <= 1'b0;
          pend_osc_q <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(flags_o.lo && flags_o.hi)); // R8
  AST_LO_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osc_rise_i |=> !flags_o.lo); // R8
  AST_HI_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_rise_i |=> !flags_o.hi); // R8
  AST_SIM_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_rise_i && osc_rise_i) |=> (!flags_o.lo && !flags_o.hi)); // R9
endmodule

// File: rtl/pfd_xor_disc.sv
module pfd_xor_disc
  import pfd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = PFD_SYNC_DEPTH
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_i,
  input  logic osc_i,
  output logic out_o,
  output logic out_no
);
  localparam int unsigned NCH = 2;  // 0: reference, 1: oscillator

  logic [NCH-1:0] in_w, rise_w, half_w;
  fd_flags_t      flags;
  logic           out_d;

  assign in_w = {osc_i, ref_i};

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .in_i  (in_w[c]),
      .rise_o(rise_w[c])
    );
    pfd_half u_half (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .rise_i(rise_w[c]),
      .half_o(half_w[c])
    );
  end

  pfd_freq_flags u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ref_rise_i(rise_w[0]),
    .osc_rise_i(rise_w[1]),
    .flags_o   (flags)
  );

  // flags override the phase XOR
  assign out_d = flags.lo | (~flags.hi & (half_w[0] ^ half_w[1]));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_o  <= 1'b0;
      out_no <= 1'b1;
    end else begin
      out_o  <= out_d;
      out_no <= ~out_d;
    end
  end

  AST_LO_FORCES_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags.lo |=> out_o); // R6
  AST_HI_FORCES_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags.hi |=> !out_o); // R7
  AST_OUT_COMPL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_no == !out_o); // R10
  AST_NO_EDGE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (half_w == '0 && flags == '0) |=> !out_o); // R1
endmodule

// File: tb/pfd_xor_disc_test.sv
`timescale 1ns/1ps
module pfd_xor_disc_test;
  localparam int WIN = 640;

  logic clk = 1'b0, rst_ni = 1'b0, ref_i = 1'b0, osc_i = 1'b0;
  logic out_o, out_no;

  pfd_xor_disc uut (
    .clk_i (clk),
    .rst_ni(rst_ni),
    .ref_i (ref_i),
    .osc_i (osc_i),
    .out_o (out_o),
    .out_no(out_no)
  );

  always #10 clk = ~clk;

  typedef struct {
    string tag;
    int    lo;
    int    hi;
  } exp_t;

  exp_t q[$];
  int   pushed = 0, done_cnt = 0;
  int   n_tests = 0, n_fail = 0;

  int pr = 40, pw_r = 20, po = 40, pw_o = 20, tr = 0, to = 0;
  bit run = 1'b0, on_r = 1'b0, on_o = 1'b0;

  // stimulus generator: counters wrap to 0 on a rising edge
  initial forever begin
    @(negedge clk);
    if (!run) begin
      ref_i = 1'b0; osc_i = 1'b0; on_r = 1'b0; on_o = 1'b0;
    end else begin
      tr = (tr + 1) % pr;
      to = (to + 1) % po;
      if (tr == 0) on_r = 1'b1;
      if (to == 0) on_o = 1'b1;
      ref_i = on_r && (tr < pw_r);
      osc_i = on_o && (to < pw_o);
    end
  end

  task automatic check(string tag, int act, int exp_v);
    n_tests++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic scen(string tag, int p_r, int w_r, int p_o, int w_o,
                      int off_r, int off_o, int lo, int hi, bit do_rst);
    exp_t e;
    tick();
    run = 1'b0;
    if (do_rst) rst_ni = 1'b0;
    repeat (3) tick();
    pr = p_r; pw_r = w_r; po = p_o; pw_o = w_o;
    tr = p_r - 1 - off_r;
    to = p_o - 1 - off_o;
    rst_ni = 1'b1;
    run = 1'b1;
    repeat (200) tick();
    e.tag = tag; e.lo = lo; e.hi = hi;
    q.push_back(e);
    pushed++;
    wait (done_cnt == pushed);
  endtask

  // monitor: counts high cycles over a window and scores them
  initial forever begin
    exp_t e;
    int hcnt, mis;
    wait (pushed > done_cnt);
    e = q[0];
    hcnt = 0; mis = 0;
    repeat (WIN) begin
      @(negedge clk);
      if (out_o) hcnt++;
      if (out_no !== ~out_o) mis++;
    end
    n_tests++;
    if (hcnt < e.lo || hcnt > e.hi) begin
      n_fail++;
      $display("FAIL %s high=%0d expected %0d..%0d", e.tag, hcnt, e.lo, e.hi);
    end
    check({e.tag, " R10 complement"}, mis, 0);
    void'(q.pop_front());
    done_cnt++;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) tick();
    check("R1 reset out_o", int'(out_o), 0);
    check("R1 reset out_no", int'(out_no), 1);
    rst_ni = 1'b1;
    repeat (50) tick();
    check("R1 idle out_o", int'(out_o), 0);

    scen("R9 aligned edges",       40, 20, 40, 20,  0,  0,   0,   0, 1'b1);
    scen("R3 osc lags 10",         40, 20, 40, 20,  0, 10, 160, 160, 1'b1);
    scen("R4 half period",         40, 20, 40, 20,  0, 20, 320, 320, 1'b1);
    scen("R5 osc lags 30",         40, 20, 40, 20,  0, 30, 480, 480, 1'b1);
    scen("R5 osc lags 39",         40, 20, 40, 20,  0, 39, 624, 624, 1'b1);
    scen("R2 pulse widths",        40,  5, 40, 35,  0, 20, 320, 320, 1'b1);
    scen("R3 osc leads 10",        40, 20, 40, 20, 10,  0, 160, 160, 1'b1);
    scen("R6 ref 4x osc",          10,  5, 40, 20,  0,  5, 352, WIN, 1'b1);
    scen("R7 osc 4x ref",          40, 20, 10,  5,  5,  0,   0, 288, 1'b1);
    scen("R8 relock no reset",     40, 20, 40, 20,  0, 20, 320, 320, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule